// File: doc/BRIEF.md
# Target Bus Phase Sequencer

This block is the target-side sequencer of a parallel peripheral bus. While the bus is idle it watches the select line, the data lines and its own ID. When it is selected it claims the bus and then walks through the information transfer phases in a fixed order. The order is command, then an optional data phase in either direction, then status, then message. After the message byte it releases the bus.

For each phase it drives the control/data, input/output and message lines with a fixed encoding. It then asks an external handshake engine for one byte transfer at a time, using a request/acknowledge pair. It captures the command bytes from the data lines. The number of command bytes comes from the first byte. The data phase direction and length are local inputs, sampled when the command phase ends. A bus reset line returns everything to idle.

Top module: `tgt_phase_seq`

## Requirements
- R1: Selection is recognised only when `bus_sel_i` is high, `bus_data_i[own_id_i]` is high, and `bus_bsy_i` and `bus_io_i` are low on SEL_SETTLE+1 consecutive clock edges. `bsy_o` rises on the edge after the last of them. Any break in that run restarts the count.
- R2: In the command phase `cd_o`=1, `io_o`=0 and `msg_o`=0.
- R3: The command phase length comes from bits [7:5] of the first command byte. Group 0 gives 6 bytes, groups 1 and 2 give 10 bytes, and groups 3 to 7 give 6 bytes.
- R4: `dir_in_i` and `xfer_len_i` are sampled on the edge that ends the command phase. A length of 0 skips the data phase. Otherwise exactly that many bytes are moved in a data phase. With `dir_in_i`=1 the lines are `io_o`=1, `cd_o`=0, `msg_o`=0. With `dir_in_i`=0 all three lines are 0.
- R5: Each accepted command byte appears on `cmd_byte_o`, with its position (0 first) on `cmd_idx_o` and a one-cycle `cmd_wr_o` pulse, one edge after the acknowledge.
- R6: In the status phase `cd_o`=1, `io_o`=1, `msg_o`=0, exactly one byte is moved, and `tx_byte_o` equals `status_i`. In every other state `tx_byte_o` is 0.
- R7: In the message phase `cd_o`, `io_o` and `msg_o` are all 1, exactly one byte is moved, and `tx_byte_o` is 0x00.
- R8: Two edges after the message byte is acknowledged, `bsy_o` and all phase lines return to 0. The phase lines are never high while `bsy_o` is low.
- R9: In each phase, `xfer_req_o` first rises PH_SETTLE+1 edges after the phase lines change. It falls on the edge that samples `xfer_ack_i` high, and within a phase it rises again on the next edge. An acknowledge while the request is low has no effect. Phase lines change only on the edge after the last acknowledge of a phase, while the request is low.
- R10: `bus_rst_i` sampled high forces every output to 0 and the sequencer to idle on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_rst_i | input | 1 | Bus reset line, active high |
| bus_sel_i | input | 1 | Bus select line |
| bus_bsy_i | input | 1 | Bus busy line |
| bus_io_i | input | 1 | Bus input/output line as seen on the bus |
| bus_data_i | input | DW | Bus data lines |
| own_id_i | input | $clog2(DW) | This target's ID bit position |
| dir_in_i | input | 1 | Data phase direction, 1 = target to initiator |
| xfer_len_i | input | LW | Data phase byte count, 0 = no data phase |
| status_i | input | DW | Status byte to send |
| xfer_ack_i | input | 1 | Handshake engine: byte moved |
| bsy_o | output | 1 | Busy line drive |
| cd_o | output | 1 | Control/data line drive |
| io_o | output | 1 | Input/output line drive |
| msg_o | output | 1 | Message line drive |
| xfer_req_o | output | 1 | Request for one byte transfer |
| tx_byte_o | output | DW | Byte sent in the status or message phase |
| cmd_byte_o | output | DW | Last captured command byte |
| cmd_idx_o | output | 4 | Position of the captured command byte |
| cmd_wr_o | output | 1 | Command byte capture strobe |

## Verification
`bsy_o` is due one edge after the last of the SEL_SETTLE+1 qualified selection samples. A new request is due PH_SETTLE+1 edges after the lines change. The request drops one edge after an acknowledge, a captured byte shows one edge after its acknowledge, and new phase lines appear two edges after a phase's last acknowledge. A bus reset takes effect one edge after it is sampled. The bench drives its inputs on the falling edge and steps a behavioural model on each rising edge. It compares every output 2 ns after that rising edge, once all of these registered results are in place. Byte counts per phase and the reset response are also checked directly at the end of each transaction.

// File: rtl/tps_pkg.sv
package tps_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CMD  = 3'd1,
    PH_DIN  = 3'd2,
    PH_DOUT = 3'd3,
    PH_STAT = 3'd4,
    PH_MSG  = 3'd5
  } phase_e;

  typedef struct packed {
    logic cd;
    logic io;
    logic msg;
  } lines_t;

  // Fixed line encoding for each phase.
  function automatic lines_t phase_lines(phase_e p);
    lines_t l;
    case (p)
      PH_CMD:  l = '{cd: 1'b1, io: 1'b0, msg: 1'b0};
      PH_DIN:  l = '{cd: 1'b0, io: 1'b1, msg: 1'b0};
      PH_STAT: l = '{cd: 1'b1, io: 1'b1, msg: 1'b0};
      PH_MSG:  l = '{cd: 1'b1, io: 1'b1, msg: 1'b1};
      default: l = '{cd: 1'b0, io: 1'b0, msg: 1'b0};
    endcase
    return l;
  endfunction

  // Command length derived from the group field of the first byte.
  function automatic logic [3:0] group_len(logic [2:0] grp);
    logic [3:0] n;
    case (grp)
      3'd1, 3'd2: n = 4'd10;
      default:    n = 4'd6;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tps_sel_detect.sv
module tps_sel_detect #(
  parameter int DW     = 8,
  parameter int SETTLE = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  bus_sel_i,
  input  logic                  bus_bsy_i,
  input  logic                  bus_io_i,
  input  logic [DW-1:0]         bus_data_i,
  input  logic [$clog2(DW)-1:0] own_id_i,
  output logic                  sel_ok_o
);
  localparam int CW = $clog2(SETTLE + 1);

  logic          cond;
  logic [CW-1:0] cnt_q, cnt_d;

  assign cond = bus_sel_i & bus_data_i[own_id_i] & ~bus_bsy_i & ~bus_io_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || !cond)               cnt_d = '0;
    else if (cnt_q != CW'(SETTLE))    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign sel_ok_o = cond && (cnt_q == CW'(SETTLE));

  // R1: a selection report needs the condition on the previous edge too
  p_sel_qualified_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ok_o |-> $past(cond));

endmodule

// File: rtl/tps_byte_pacer.sv
module tps_byte_pacer #(
  parameter int LW     = 8,
  parameter int SETTLE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          start_i,
  input  logic          ack_i,
  input  logic [LW-1:0] need_i,
  output logic          req_o,
  output logic [LW-1:0] idx_o,
  output logic          fire_o,
  output logic          last_o
);
  localparam int WW = $clog2(SETTLE + 1);

  logic [WW-1:0] wait_q, wait_d;
  logic [LW-1:0] idx_q, idx_d;
  logic          req_q, req_d;
  logic          halt_q, halt_d;

  assign fire_o = !clr_i && !start_i && !halt_q && (wait_q == '0) && req_q && ack_i;
  assign last_o = fire_o && (idx_q == need_i - 1'b1);

  always_comb begin
    wait_d = wait_q;
    idx_d  = idx_q;
    req_d  = req_q;
    halt_d = halt_q;
    if (clr_i) begin
      wait_d = '0;
      idx_d  = '0;
      req_d  = 1'b0;
      halt_d = 1'b1;
    end else if (start_i) begin
      wait_d = WW'(SETTLE);
      idx_d  = '0;
      req_d  = 1'b0;
      halt_d = 1'b0;
    end else if (!halt_q) begin
      if (wait_q != '0) begin
        wait_d = wait_q - 1'b1;
      end else if (req_q) begin
        if (ack_i) begin
          req_d = 1'b0;
          if (last_o) halt_d = 1'b1;
          else        idx_d  = idx_q + 1'b1;
        end
      end else begin
        req_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      idx_q  <= '0;
      req_q  <= 1'b0;
      halt_q <= 1'b1;
    end else begin
      wait_q <= wait_d;
      idx_q  <= idx_d;
      req_q  <= req_d;
      halt_q <= halt_d;
    end
  end

  assign req_o = req_q;
  assign idx_o = idx_q;

  // R9: a request never stands while the pacer is halted
  p_req_not_halted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> !halt_q);

  // R9: after an accepted byte the request is low on the next edge
  p_req_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !req_q);

endmodule

// File: rtl/tps_phase_fsm.sv
module tps_phase_fsm
  import tps_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rst_i,
  input  logic          sel_ok_i,
  input  logic          last_i,
  input  logic          req_i,
  input  logic          dir_in_i,
  input  logic [LW-1:0] xfer_len_i,
  output phase_e        state_o,
  output logic          start_o,
  output logic [LW-1:0] dlen_o
);
  phase_e        state_q, state_d;
  logic          pend_q, pend_d;
  logic [LW-1:0] dlen_q, dlen_d;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    dlen_d  = dlen_q;
    start_o = 1'b0;
    if (bus_rst_i) begin
      state_d = PH_IDLE;
      pend_d  = 1'b0;
      dlen_d  = '0;
    end else if (state_q == PH_IDLE) begin
      if (sel_ok_i) begin
        state_d = PH_CMD;
        start_o = 1'b1;
      end
    end else if (pend_q) begin
      pend_d  = 1'b0;
      start_o = 1'b1;
      case (state_q)
        PH_CMD: begin
          dlen_d = xfer_len_i;
          if (xfer_len_i == '0) state_d = PH_STAT;
          else if (dir_in_i)    state_d = PH_DIN;
          else                  state_d = PH_DOUT;
        end
        PH_DIN, PH_DOUT: state_d = PH_STAT;
        PH_STAT:         state_d = PH_MSG;
        default: begin
          state_d = PH_IDLE;
          start_o = 1'b0;
        end
      endcase
    end else if (last_i) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      pend_q  <= 1'b0;
      dlen_q  <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      dlen_q  <= dlen_d;
    end
  end

  assign state_o = state_q;
  assign dlen_o  = dlen_q;

  // R9: the phase cannot move on an edge where the request was high
  p_lines_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !bus_rst_i) |=> (state_q == $past(state_q)));

  // R8: leaving the message phase always lands in idle
  p_msg_to_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == PH_MSG && state_q != PH_MSG) |-> (state_q == PH_IDLE));

endmodule

// File: rtl/tgt_phase_seq.sv
module tgt_phase_seq
  import tps_pkg::*;
#(
  parameter int DW         = 8,
  parameter int LW         = 8,
  parameter int SEL_SETTLE = 4,
  parameter int PH_SETTLE  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_rst_i,
  input  logic                  bus_sel_i,
  input  logic                  bus_bsy_i,
  input  logic                  bus_io_i,
  input  logic [DW-1:0]         bus_data_i,
  input  logic [$clog2(DW)-1:0] own_id_i,
  input  logic                  dir_in_i,
  input  logic [LW-1:0]         xfer_len_i,
  input  logic [DW-1:0]         status_i,
  input  logic                  xfer_ack_i,
  output logic                  bsy_o,
  output logic                  cd_o,
  output logic                  io_o,
  output logic                  msg_o,
  output logic                  xfer_req_o,
  output logic [DW-1:0]         tx_byte_o,
  output logic [DW-1:0]         cmd_byte_o,
  output logic [3:0]            cmd_idx_o,
  output logic                  cmd_wr_o
);
  localparam logic [3:0] DEF_LEN = 4'd6;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  logic          sel_ok, start, fire, last, req;
  logic [LW-1:0] idx, need, dlen;
  phase_e        state;
  lines_t        lines;

  tps_sel_detect #(.DW(DW), .SETTLE(SEL_SETTLE)) u_sel (
    .clk(clk), .rst_n(rst_sn), .clr_i(bus_rst_i),
    .bus_sel_i(bus_sel_i), .bus_bsy_i(bus_bsy_i), .bus_io_i(bus_io_i),
    .bus_data_i(bus_data_i), .own_id_i(own_id_i), .sel_ok_o(sel_ok)
  );

  tps_phase_fsm #(.LW(LW)) u_fsm (
    .clk(clk), .rst_n(rst_sn), .bus_rst_i(bus_rst_i), .sel_ok_i(sel_ok),
    .last_i(last), .req_i(req), .dir_in_i(dir_in_i), .xfer_len_i(xfer_len_i),
    .state_o(state), .start_o(start), .dlen_o(dlen)
  );

  tps_byte_pacer #(.LW(LW), .SETTLE(PH_SETTLE)) u_pace (
    .clk(clk), .rst_n(rst_sn), .clr_i(bus_rst_i), .start_i(start),
    .ack_i(xfer_ack_i), .need_i(need), .req_o(req), .idx_o(idx),
    .fire_o(fire), .last_o(last)
  );

  // Command capture and command length register.
  logic [3:0]    clen_q, clen_d;
  logic [DW-1:0] cbyte_q, cbyte_d;
  logic [3:0]    cidx_q, cidx_d;
  logic          cwr_q, cwr_d;

  always_comb begin
    clen_d  = clen_q;
    cbyte_d = cbyte_q;
    cidx_d  = cidx_q;
    cwr_d   = 1'b0;
    if (bus_rst_i) begin
      clen_d  = DEF_LEN;
      cbyte_d = '0;
      cidx_d  = '0;
    end else if (fire && state == PH_CMD) begin
      cbyte_d = bus_data_i;
      cidx_d  = idx[3:0];
      cwr_d   = 1'b1;
      if (idx == '0) clen_d = group_len(bus_data_i[DW-1:DW-3]);
    end else if (start) begin
      clen_d = DEF_LEN;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      clen_q  <= DEF_LEN;
      cbyte_q <= '0;
      cidx_q  <= '0;
      cwr_q   <= 1'b0;
    end else begin
      clen_q  <= clen_d;
      cbyte_q <= cbyte_d;
      cidx_q  <= cidx_d;
      cwr_q   <= cwr_d;
    end
  end

  always_comb begin
    case (state)
      PH_CMD:          need = LW'(clen_q);
      PH_DIN, PH_DOUT: need = dlen;
      default:         need = LW'(1);
    endcase
  end

  assign lines      = phase_lines(state);
  assign bsy_o      = (state != PH_IDLE);
  assign cd_o       = lines.cd;
  assign io_o       = lines.io;
  assign msg_o      = lines.msg;
  assign xfer_req_o = req;
  assign tx_byte_o  = (state == PH_STAT) ? status_i : '0;
  assign cmd_byte_o = cbyte_q;
  assign cmd_idx_o  = cidx_q;
  assign cmd_wr_o   = cwr_q;

  // R8: phase lines only while the bus is held
  p_lines_need_bsy_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (cd_o || io_o || msg_o) |-> bsy_o);

  // R5: command bytes are captured only in the command phase
  p_capture_in_cmd_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_wr_o |-> $past(cd_o && !io_o && !msg_o));

  // R10: a sampled bus reset leaves the bus released
  p_bus_reset_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(bus_rst_i) |-> (!bsy_o && !xfer_req_o && !cmd_wr_o));

  // R3: the command phase never moves more bytes than the longest group
  p_cmd_len_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    cmd_wr_o |-> (cmd_idx_o < 4'd10));

endmodule

// File: tb/sim_tgt_phase_seq.sv
module sim_tgt_phase_seq;
  localparam int SS = 4;
  localparam int PS = 2;
  localparam int LW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rst_i = 1'b0, bus_sel_i = 1'b0, bus_bsy_i = 1'b0, bus_io_i = 1'b0;
  logic [7:0] bus_data_i = '0;
  logic [2:0] own_id_i = '0;
  logic       dir_in_i = 1'b0;
  logic [LW-1:0] xfer_len_i = '0;
  logic [7:0] status_i = '0;
  logic       xfer_ack_i = 1'b0;
  logic       bsy_o, cd_o, io_o, msg_o, xfer_req_o, cmd_wr_o;
  logic [7:0] tx_byte_o, cmd_byte_o;
  logic [3:0] cmd_idx_o;

  tgt_phase_seq u0 (
    .clk(clk), .rst_n(rst_n), .bus_rst_i(bus_rst_i), .bus_sel_i(bus_sel_i),
    .bus_bsy_i(bus_bsy_i), .bus_io_i(bus_io_i), .bus_data_i(bus_data_i),
    .own_id_i(own_id_i), .dir_in_i(dir_in_i), .xfer_len_i(xfer_len_i),
    .status_i(status_i), .xfer_ack_i(xfer_ack_i), .bsy_o(bsy_o), .cd_o(cd_o),
    .io_o(io_o), .msg_o(msg_o), .xfer_req_o(xfer_req_o), .tx_byte_o(tx_byte_o),
    .cmd_byte_o(cmd_byte_o), .cmd_idx_o(cmd_idx_o), .cmd_wr_o(cmd_wr_o)
  );

  always #4 clk = ~clk;  // 125 MHz

  int vectors = 0, fails = 0, cycles = 0;

  task automatic chk(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Stimulus control set by the scenario tasks, applied on falling edges.
  logic       sel_on = 1'b0, io_force = 1'b0, rst_force = 1'b0;
  logic [7:0] sel_data = '0;
  logic [7:0] cmdq [16];
  int         ci = 0, dly = 0, dcnt = 0, wrcnt = 0;

  always @(negedge clk) begin
    bus_bsy_i = bsy_o;
    bus_sel_i = sel_on;
    bus_io_i  = io_force;
    bus_rst_i = rst_force;
    bus_data_i = sel_on ? sel_data : 8'h00;
    if (xfer_req_o && !xfer_ack_i) begin
      if (dcnt >= dly) begin
        xfer_ack_i = 1'b1;
        dcnt = 0;
        if (cd_o && !io_o && !msg_o) begin
          bus_data_i = cmdq[ci];
          ci++;
        end
      end else dcnt++;
    end else xfer_ack_i = 1'b0;
  end

  // Behavioural reference: phase numbers 0 idle,1 cmd,2 din,3 dout,4 stat,5 msg.
  int m_rs1, m_rs2, m_st, m_sc, m_wait, m_idx, m_req, m_halt, m_pend;
  int m_clen, m_dlen, m_wr, m_byte, m_cidx;

  function automatic int grp_len(int b);
    int g = (b >> 5) & 7;
    if (g == 1 || g == 2) return 10;
    return 6;
  endfunction

  task automatic m_clear();
    m_st = 0; m_sc = 0; m_wait = 0; m_idx = 0; m_req = 0; m_halt = 1; m_pend = 0;
    m_clen = 6; m_dlen = 0; m_wr = 0; m_byte = 0; m_cidx = 0;
  endtask

  task automatic m_step();
    bit cond, ok, fire, last, start;
    int need, nst;
    if (bus_rst_i) begin m_clear(); return; end
    cond = bus_sel_i && bus_data_i[own_id_i] && !bus_bsy_i && !bus_io_i;
    ok = cond && (m_sc == SS);
    m_sc = !cond ? 0 : (m_sc < SS ? m_sc + 1 : m_sc);
    need = (m_st == 1) ? m_clen : ((m_st == 2 || m_st == 3) ? m_dlen : 1);
    fire = !m_halt && m_wait == 0 && m_req && xfer_ack_i;
    last = fire && (m_idx == need - 1);
    start = 0; nst = m_st;
    if (m_st == 0) begin
      if (ok) begin nst = 1; start = 1; end
    end else if (m_pend) begin
      m_pend = 0; start = 1;
      case (m_st)
        1: begin m_dlen = xfer_len_i; nst = (xfer_len_i == 0) ? 4 : (dir_in_i ? 2 : 3); end
        2, 3: nst = 4;
        4: nst = 5;
        default: begin nst = 0; start = 0; end
      endcase
    end else if (last) m_pend = 1;
    m_wr = 0;
    if (fire && m_st == 1) begin
      m_byte = bus_data_i; m_cidx = m_idx; m_wr = 1;
      if (m_idx == 0) m_clen = grp_len(bus_data_i);
    end else if (start) m_clen = 6;
    if (start) begin m_wait = PS; m_req = 0; m_idx = 0; m_halt = 0; end
    else if (!m_halt) begin
      if (m_wait > 0) m_wait--;
      else if (m_req) begin
        if (xfer_ack_i) begin m_req = 0; if (last) m_halt = 1; else m_idx++; end
      end else m_req = 1;
    end
    m_st = nst;
  endtask

  function automatic string line_tag(int st);
    case (st)
      1: return "R2";
      2, 3: return "R4";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin m_rs1 = 0; m_rs2 = 0; m_clear(); end
    else begin
      if (!m_rs2) m_clear(); else m_step();
      m_rs2 = m_rs1; m_rs1 = 1;
    end
    #2;
    if (rst_n) begin
      chk("R1", "bsy_o", bsy_o, m_st != 0);
      chk(line_tag(m_st), "cd_o", cd_o, m_st == 1 || m_st == 4 || m_st == 5);
      chk(line_tag(m_st), "io_o", io_o, m_st == 2 || m_st == 4 || m_st == 5);
      chk(line_tag(m_st), "msg_o", msg_o, m_st == 5);
      chk("R9", "xfer_req_o", xfer_req_o, m_req);
      chk(m_st == 5 ? "R7" : "R6", "tx_byte_o", tx_byte_o, m_st == 4 ? status_i : 0);
      chk("R5", "cmd_wr_o", cmd_wr_o, m_wr);
      chk("R5", "cmd_byte_o", cmd_byte_o, m_byte);
      chk("R5", "cmd_idx_o", cmd_idx_o, m_cidx);
      if (cmd_wr_o) wrcnt++;
    end
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #3;
  endtask

  task automatic select_and_hold(int id);
    sel_data = 8'h80 | (8'h01 << id);
    sel_on = 1'b1;
    for (int k = 0; k < 40 && !bsy_o; k++) tick();
    sel_on = 1'b0;
  endtask

  task automatic run_txn(int id, int c0, bit din, int dl, int st, int d);
    own_id_i = id[2:0]; dir_in_i = din; xfer_len_i = dl[LW-1:0];
    status_i = st[7:0]; dly = d; dcnt = 0; ci = 0; wrcnt = 0;
    for (int k = 0; k < 16; k++) cmdq[k] = (k == 0) ? c0[7:0] : 8'(c0 + 3 * k);
    select_and_hold(id);
    chk("R1", "selected", bsy_o, 1);
    for (int k = 0; k < 400 && bsy_o; k++) tick();
    chk("R8", "bus freed", bsy_o, 0);
    chk("R3", "command bytes", wrcnt, grp_len(c0));
    repeat (3) tick();
  endtask

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R10", "idle bsy after reset", bsy_o, 0);
    chk("R9", "idle req after reset", xfer_req_o, 0);

    // R1: wrong ID, short pulse, and I/O high must not select
    own_id_i = 3'd3;
    sel_data = 8'h84; sel_on = 1'b1; repeat (12) tick(); sel_on = 1'b0; tick();
    chk("R1", "wrong id", bsy_o, 0);
    sel_data = 8'h88; sel_on = 1'b1; repeat (SS) tick(); sel_on = 1'b0; repeat (3) tick();
    chk("R1", "short select", bsy_o, 0);
    io_force = 1'b1; sel_on = 1'b1; repeat (12) tick(); sel_on = 1'b0; io_force = 1'b0; tick();
    chk("R1", "io high", bsy_o, 0);
    repeat (3) tick();

    run_txn(3, 8'h08, 1'b1, 3, 8'h02, 0);   // group 0, data in
    run_txn(5, 8'h28, 1'b0, 2, 8'h00, 2);   // group 1, data out
    run_txn(3, 8'hA0, 1'b1, 0, 8'h08, 1);   // group 5, no data phase
    run_txn(0, 8'h5A, 1'b1, 1, 8'h18, 0);   // group 2
    run_txn(6, 8'h3F, 1'b0, 4, 8'h22, 1);   // group 1, odd bytes

    // R10: bus reset in the middle of a data-in phase
    own_id_i = 3'd2; dir_in_i = 1'b1; xfer_len_i = 8'd5; dly = 1; ci = 0;
    for (int k = 0; k < 16; k++) cmdq[k] = 8'(k);
    select_and_hold(2);
    for (int k = 0; k < 200 && !(io_o && !cd_o); k++) tick();
    chk("R4", "reached data in", io_o, 1);
    rst_force = 1'b1;
    @(posedge clk); #2;
    chk("R10", "bsy after bus reset", bsy_o, 0);
    chk("R10", "lines after bus reset", {cd_o, io_o, msg_o}, 0);
    chk("R10", "req after bus reset", xfer_req_o, 0);
    #1 rst_force = 1'b0;
    repeat (4) tick();

    run_txn(4, 8'h12, 1'b0, 3, 8'h30, 0);  // recovery after bus reset

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule